// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the device-side read path of a synchronous burst memory with 16-bit words. The host drops chip enable and pulses the address-valid strobe with a start address. The block then waits a programmed number of clock edges and raises a ready flag when the first word is on the data outputs. After that it presents one word per active clock edge, either in a straight line or inside an aligned wrap window. The memory array is a computed read-only model: the word at address `a` is `a[15:0] ^ 16'hC35A`.

An 8-bit settings register holds the burst parameters and can only be written while chip enable is high. Lifting output enable mid-burst freezes the stream, and dropping it again continues from the next unread word. In linear mode the stream pauses for one edge after it has shown a word at offset 3Fh of a 64-word segment. An odd start address adds one edge to the initial wait. Raising chip enable abandons the burst.

Top module: `sburst_read`

## Requirements
- R1: After reset the settings register holds 8'h87: wait code 7, linear order, rising edge, ready active high, synchronous reads on. With chip enable high, ready is at its inactive level.
- R2: The register is loaded from `cfg_din` at a rising `clk` edge where `cfg_wr` is 1 and `ce_n` is 1. A write while `ce_n` is 0 has no effect. The fields are: bits [2:0] wait code, bits [4:3] order, bit 5 edge select, bit 6 ready polarity, bit 7 synchronous enable.
- R3: The address is latched at an active edge with `ce_n`=0 and `adv_n`=0. For an even start, the first word and the ready assertion appear at the edge `code+2` edges after the latch edge.
- R4: An odd start address adds exactly one edge to the initial wait.
- R5: The word shown for address `a` is `a[15:0] ^ 16'hC35A`. In order 0 (linear), each following word comes from the address plus one.
- R6: In orders 1, 2 and 3 the address steps through an aligned window of 8, 16 or 32 words and wraps back to the window start. No boundary gap is inserted in these orders.
- R7: In linear order, after a word whose address has low six bits equal to 3Fh, the next active edge with output enable low shows no word and ready is deasserted. The following word comes one edge later.
- R8: An active edge with `oe_n`=1 deasserts ready and does not advance the address. The first later edge with `oe_n`=0 shows the next unread word. This also holds during the initial wait.
- R9: `rdy_drv` equals the inverse of `ce_n`, whatever `oe_n` is. `dq_drv` is 1 only when both `ce_n` and `oe_n` are 0.
- R10: An active edge with `ce_n`=1 ends the burst. Ready goes inactive, and no word appears afterwards until a new address is latched.
- R11: With bit 5 set, every engine action takes place on the falling edge of `clk`.
- R12: With bit 6 set, the `rdy` pin is low while a word is valid and high otherwise.
- R13: With bit 7 clear, the address strobe is ignored and no burst starts.
- R14: A new address strobe during a burst restarts the wait with the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Settings register write strobe |
| cfg_din | input | 8 | Settings register write value |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Burst start address |
| dq | output | DW | Read data word |
| dq_drv | output | 1 | Data output driver enable |
| rdy | output | 1 | Ready pin level |
| rdy_drv | output | 1 | Ready driver enable |

## Verification
Every engine result appears at an active edge. The first word appears `code+2` edges after the latch edge, plus one edge for an odd start. Each later word takes one more edge, a boundary gap takes one extra edge, and suspension and abort act at the same edge that sees `oe_n` or `ce_n` high. The driver enables follow the pins combinationally, and the settings register changes at the rising edge of the write. The bench steps a behavioural model on each active edge, using the input levels it holds there. It then compares every output 2 ns later, well before the opposite clock edge. The latency checks count edges from the latch edge to the first observed ready.

// File: rtl/sburst_read.sv
`timescale 1ns/1ps
module sburst_read #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int SEG = 64,
  parameter logic [7:0] CFG_RST = 8'h87,
  parameter logic [DW-1:0] KEY = 'hC35A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_din,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dq,
  output logic          dq_drv,
  output logic          rdy,
  output logic          rdy_drv
);
  localparam int SEGW = $clog2(SEG);
  localparam int CNTW = 4;

  logic [7:0] cfg;
  logic [2:0] ws;
  logic [1:0] bmode;
  logic fall_sel, rdy_lo, sync_en, eclk;
  logic busy, valid, bubble, at_seg_end;
  logic [CNTW-1:0] cnt;
  logic [AW-1:0] nxt, nxt_inc, wmask;

  assign ws       = cfg[2:0];
  assign bmode    = cfg[4:3];
  assign fall_sel = cfg[5];
  assign rdy_lo   = cfg[6];
  assign sync_en  = cfg[7];
  assign eclk     = clk ^ fall_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= CFG_RST;
    else if (cfg_wr && ce_n) cfg <= cfg_din;

  always_comb begin
    case (bmode)
      2'd1:    wmask = AW'(7);
      2'd2:    wmask = AW'(15);
      2'd3:    wmask = AW'(31);
      default: wmask = '1;
    endcase
    nxt_inc    = (nxt & ~wmask) | ((nxt + AW'(1)) & wmask);
    at_seg_end = (bmode == 2'd0) && (&nxt[SEGW-1:0]);
  end

  always_ff @(posedge eclk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; valid <= 1'b0; bubble <= 1'b0;
      cnt <= '0; nxt <= '0; dq <= '0;
    end else if (ce_n) begin
      busy <= 1'b0; valid <= 1'b0; bubble <= 1'b0; cnt <= '0;
    end else if (!adv_n && sync_en) begin
      busy <= 1'b1; valid <= 1'b0; bubble <= 1'b0; nxt <= addr;
      cnt <= CNTW'(ws) + CNTW'(1) + CNTW'(addr[0]);
    end else if (!busy) begin
      valid <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CNTW'(1);
      valid <= 1'b0;
    end else if (oe_n || bubble) begin
      valid <= 1'b0;
      if (!oe_n) bubble <= 1'b0;
    end else begin
      dq <= nxt[DW-1:0] ^ KEY;
      valid <= 1'b1;
      bubble <= at_seg_end;
      nxt <= nxt_inc;
    end

  assign dq_drv  = ~ce_n & ~oe_n;
  assign rdy_drv = ~ce_n;
  assign rdy     = (valid & ~ce_n) ^ rdy_lo;
endmodule

module sburst_read_chk (
  input logic       clk,
  input logic       eclk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       adv_n,
  input logic       oe_n,
  input logic [7:0] cfg,
  input logic       busy,
  input logic       bubble,
  input logic       valid
);
  // R10
  abort_idle_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    ce_n |=> !valid);
  // R8
  suspend_hold_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> !valid);
  // R13
  no_sync_start_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    (!ce_n && !adv_n && !cfg[7] && !busy) |=> !busy);
  // R3
  word_needs_oe_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    $rose(valid) |-> $past(!ce_n && !oe_n));
  // R7
  seg_gap_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    (!ce_n && adv_n && !oe_n && busy && bubble) |=> !valid);
  // R2
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |=> $stable(cfg));
endmodule

bind sburst_read sburst_read_chk u_chk (
  .clk(clk), .eclk(eclk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
  .oe_n(oe_n), .cfg(cfg), .busy(busy), .bubble(bubble), .valid(valid)
);

// File: tb/sburst_read_test.sv
`timescale 1ns/1ps
module sburst_read_test;
  logic clk = 0, rst_n = 0, cfg_wr = 0, ce_n = 1, adv_n = 1, oe_n = 1;
  logic [7:0] cfg_din = 0;
  logic [21:0] addr = 0;
  wire [15:0] dq;
  wire dq_drv, rdy, rdy_drv;

  sburst_read uut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
    .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n), .addr(addr), .dq(dq),
    .dq_drv(dq_drv), .rdy(rdy), .rdy_drv(rdy_drv));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R1";

  logic [7:0] m_cfg = 8'h87;
  bit m_busy = 0, m_valid = 0, m_bub = 0;
  int m_cnt = 0;
  logic [21:0] m_nxt = 0;
  logic [15:0] m_dq = 0;

  function automatic logic [21:0] m_step(logic [21:0] a);
    int span;
    case (m_cfg[4:3])
      2'd0: return a + 22'd1;
      2'd1: span = 8;
      2'd2: span = 16;
      default: span = 32;
    endcase
    return 22'((int'(a) / span) * span + (int'(a) + 1) % span);
  endfunction

  task automatic m_edge();
    if (ce_n) begin m_busy = 0; m_valid = 0; m_bub = 0; m_cnt = 0; end
    else if (!adv_n && m_cfg[7]) begin
      m_busy = 1; m_valid = 0; m_bub = 0; m_nxt = addr;
      m_cnt = int'(m_cfg[2:0]) + 1 + int'(addr[0]);
    end
    else if (!m_busy) m_valid = 0;
    else if (m_cnt > 0) begin m_cnt--; m_valid = 0; end
    else if (oe_n) m_valid = 0;
    else if (m_bub) begin m_bub = 0; m_valid = 0; end
    else begin
      m_dq = m_nxt[15:0] ^ 16'hC35A;
      m_valid = 1;
      m_bub = (m_cfg[4:3] == 2'd0) && (m_nxt[5:0] == 6'h3F);
      m_nxt = m_step(m_nxt);
    end
  endtask

  task automatic check(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  task automatic compare();
    bit er;
    er = (m_valid && !ce_n) ^ m_cfg[6];
    check(rdy_drv == !ce_n, "R9 ready drive", rdy_drv, !ce_n);
    check(dq_drv == (!ce_n && !oe_n), "R9 data drive", dq_drv, !ce_n && !oe_n);
    check(rdy == er, "ready level", rdy, er);
    if (m_valid && !ce_n && !oe_n) check(dq == m_dq, "R5 data word", dq, m_dq);
  endtask

  task automatic step();
    if (m_cfg[5]) @(negedge clk); else @(posedge clk);
    m_edge();
    #2 compare();
  endtask

  task automatic wcfg(logic [7:0] v);
    cfg_wr = 1; cfg_din = v;
    @(posedge clk);
    if (!m_cfg[5]) m_edge();
    if (ce_n) begin m_cfg = v; m_busy = 0; m_valid = 0; m_bub = 0; m_cnt = 0; end
    #2 cfg_wr = 0;
    compare();
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; adv_n = 1;
    step();
  endtask

  task automatic burst(logic [21:0] a, int nwords, int exp_lat);
    int k, got, first;
    k = 0; got = 0; first = -1;
    ce_n = 0; adv_n = 0; oe_n = 0; addr = a;
    step();
    adv_n = 1;
    while (got < nwords && k < 60) begin
      step(); k++;
      if (rdy != m_cfg[6]) begin
        if (first < 0) first = k;
        got++;
      end
    end
    check(first == exp_lat, "first word latency", first, exp_lat);
    check(got == nwords, "word count", got, nwords);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #14 rst_n = 1;
    cur = "R1";
    compare();
    check(rdy == 1'b0, "R1 ready inactive after reset", rdy, 0);
    step(); step();
    burst(22'h100, 5, 9); idle();

    cur = "R3";
    wcfg(8'h80); burst(22'h10, 6, 2); idle();
    wcfg(8'h84); burst(22'h20, 4, 6); idle();

    cur = "R4";
    wcfg(8'h81); burst(22'h11, 5, 4); idle();
    burst(22'h3, 3, 4); idle();

    cur = "R5";
    burst(22'h200, 12, 3); idle();

    cur = "R6";
    wcfg(8'h88); burst(22'h25, 12, 3); idle();
    wcfg(8'h90); burst(22'h1A, 20, 2); idle();
    wcfg(8'h98); burst(22'h3A, 40, 2); idle();

    cur = "R7";
    wcfg(8'h80); burst(22'h3C, 8, 2); idle();
    burst(22'h7F, 4, 3); idle();

    cur = "R8";
    ce_n = 0; adv_n = 0; oe_n = 0; addr = 22'h40; step();
    adv_n = 1; repeat (4) step();
    oe_n = 1;
    repeat (3) begin
      step();
      check(rdy == m_cfg[6], "R8 ready off while suspended", rdy, m_cfg[6]);
      check(rdy_drv == 1'b1, "R9 ready still driven", rdy_drv, 1);
    end
    oe_n = 0; repeat (4) step(); idle();
    ce_n = 0; adv_n = 0; oe_n = 1; addr = 22'h52; step();
    adv_n = 1; repeat (5) step();
    oe_n = 0; repeat (3) step(); idle();
    ce_n = 0; adv_n = 0; oe_n = 0; addr = 22'h3E; step();
    adv_n = 1; repeat (4) step();
    oe_n = 1; repeat (2) step();
    oe_n = 0; repeat (4) step(); idle();

    cur = "R10";
    burst(22'h80, 3, 2);
    ce_n = 1; step();
    check(rdy == m_cfg[6], "R10 ready off after abort", rdy, m_cfg[6]);
    ce_n = 0; oe_n = 0;
    repeat (4) begin
      step();
      check(rdy == m_cfg[6], "R10 no word after abort", rdy, m_cfg[6]);
    end
    idle();

    cur = "R14";
    burst(22'h100, 2, 2);
    burst(22'h301, 3, 3); idle();

    cur = "R12";
    wcfg(8'hC0); burst(22'h55, 4, 3); idle();
    check(rdy == 1'b1, "R12 idle level high when active low", rdy, 1);

    cur = "R11";
    wcfg(8'hA1); burst(22'h6, 4, 3); idle();
    burst(22'h3F, 5, 4); idle();
    wcfg(8'h80);

    cur = "R13";
    wcfg(8'h00);
    ce_n = 0; adv_n = 0; oe_n = 0; addr = 22'h10; step();
    adv_n = 1;
    repeat (10) begin
      step();
      check(rdy == 1'b0, "R13 no burst when sync off", rdy, 0);
    end
    idle();

    cur = "R2";
    wcfg(8'h81);
    ce_n = 0; adv_n = 0; oe_n = 0; addr = 22'h8; step();
    adv_n = 1; step();
    wcfg(8'h87);
    step(); step(); idle();
    burst(22'h8, 3, 3); idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule